// File: doc/BRIEF.md
# Chase Test-Vector Selection by Evaluation-Value Tree Walk

The block chooses which test vectors of a Chase-style soft-decision decoder go on to full interpolation. It never builds an interpolation polynomial. For each test vector it derives the one finite-field value whose zero test decides selection. Software-visible state is not part of it. A preceding stage loads a root set of evaluation values. For every point, this set holds the values of the two running polynomials Q0 and Q1 at that point, together with the point's x coordinate. Points 2k and 2k+1 are the hard-decision and second-choice candidates of unreliable position k. The last point, index 2·ETA, is the preset test point.

After `start`, the block walks the binary tree of test vectors depth-first. Each edge takes one candidate point as pivot. That point's two stored values act as discrepancies. The block applies one interpolation-style update to the values of every later point, at one point per clock, and writes the results into the storage slot of the next level. Each level keeps one value set and one pair of weighted degrees. On backtrack, the walk resumes from the stored level without recomputing anything above it. At each leaf, one clock tests the value of the lower-degree polynomial at the test point. The walk stops once two vectors qualify or the tree is exhausted.

Top module: `tvt_eval_tree`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `found_cnt` are all 0.
- R2: The vector index encodes the choice at level k in bit ETA-1-k: 0 means the hard-decision point 2k and 1 means the second-choice point 2k+1. Leaves are visited in ascending index order. `first_vec` is the lowest qualifying index and `second_vec` is the next one. `found_cnt` reports how many vectors were found, capped at 2.
- R3: The pivot at an edge is chosen as follows. Q0 is the pivot if its discrepancy is nonzero and either Q1's discrepancy is zero or deg0 <= deg1. Otherwise Q1 is the pivot if its discrepancy is nonzero. If both discrepancies are zero, nothing changes. For every later point j, the pivot's value becomes v·(x_j XOR x_pivot). The other polynomial's value becomes d_pivot·v_other XOR d_other·v_pivot. The pivot's degree rises by one. All arithmetic is in GF(2^M) with modulus POLY.
- R4: A leaf qualifies when the lower-degree polynomial (Q0 on a tie) evaluates to zero at the test point. The initial degrees are 0 for Q0 and INIT_DEG1 for Q1.
- R5: If both values at the test point are loaded as zero, vectors 0 and 1 are selected with `found_cnt`=2 and `fail`=0.
- R6: If fewer than two vectors qualify, every leaf is visited and `done` comes with `fail`=1 and `found_cnt` equal to 0 or 1.
- R7: The walk ends right after the leaf test that finds the second qualifying vector, so such a run takes far fewer cycles than a full walk.
- R8: `done` is a one-cycle pulse. The results hold until the next `start`. While `busy`, both `start` and `ld_en` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one root point (ignored while busy) |
| ld_pt | input | AW | Point index, 0..2·ETA |
| ld_x | input | M | x coordinate of the point |
| ld_v0 | input | M | Root value of Q0 at the point |
| ld_v1 | input | M | Root value of Q1 at the point |
| start | input | 1 | Begin the tree walk |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| found_cnt | output | 2 | Qualifying vectors found (0..2) |
| first_vec | output | ETA | Index of first selected vector |
| second_vec | output | ETA | Index of second selected vector |
| fail | output | 1 | Fewer than two vectors qualified |

## Verification
The bench targets the following corner cases:
- A degree tie at a leaf. A design that picks Q1 on a tie selects the wrong vectors or reports failure.
- Pivots whose discrepancies are both zero. A design that updates anyway corrupts the values further down the tree.
- A zero test point, where stopping early shows up as a short run. A design that stops late or never sets the cycle count much higher.
- Runs with fewer than two hits. A design that ends the walk early, or that mis-restores a level's values or degrees on backtrack, reports the wrong vectors or leaves `fail` wrong.
- A `start` and a load that arrive mid-walk. A design that accepts either restarts, corrupts its results, or emits extra `done` pulses.

// File: rtl/tvt_pkg.sv
package tvt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EDGE,
        ST_TEST
    } tvt_state_e;

    typedef enum logic [1:0] {
        PV_NONE,
        PV_Q0,
        PV_Q1
    } pivot_e;

    // Pivot choice: lower weighted degree among nonzero discrepancies, Q0 on tie.
    function automatic pivot_e pick_pivot(input logic nz0, input logic nz1,
                                          input logic q0_not_higher);
        if (nz0 && (!nz1 || q0_not_higher))
            return PV_Q0;
        else if (nz1)
            return PV_Q1;
        else
            return PV_NONE;
    endfunction

endpackage

// File: rtl/tvt_point_update.sv
module tvt_point_update
    import tvt_pkg::*;
#(
    parameter int M = 8,
    parameter logic [M:0] POLY = 9'h11D
) (
    input  pivot_e         piv,
    input  logic [M-1:0]   d0,
    input  logic [M-1:0]   d1,
    input  logic [M-1:0]   xp,
    input  logic [M-1:0]   xj,
    input  logic [M-1:0]   v0,
    input  logic [M-1:0]   v1,
    output logic [M-1:0]   n0,
    output logic [M-1:0]   n1
);

    function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc;
        logic [M-1:0] t;
        acc = '0;
        t   = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) acc = acc ^ t;
            t = t[M-1] ? ({t[M-2:0], 1'b0} ^ POLY[M-1:0]) : {t[M-2:0], 1'b0};
        end
        return acc;
    endfunction

    logic [M-1:0] dx;
    assign dx = xj ^ xp;

    always_comb begin
        n0 = v0;
        n1 = v1;
        case (piv)
            PV_Q0: begin
                n0 = gmul(v0, dx);
                n1 = gmul(d0, v1) ^ gmul(d1, v0);
            end
            PV_Q1: begin
                n1 = gmul(v1, dx);
                n0 = gmul(d1, v0) ^ gmul(d0, v1);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tvt_level_store.sv
module tvt_level_store #(
    parameter int M    = 8,
    parameter int NLEV = 4,
    parameter int NPT  = 2*NLEV+1,
    parameter int AW   = $clog2(NPT),
    parameter int LW   = $clog2(NLEV+1)
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [LW-1:0]   wr_lvl,
    input  logic [AW-1:0]   wr_pt,
    input  logic [2*M-1:0]  wr_v,
    input  logic [LW-1:0]   rd_lvl,
    input  logic            rd_sel,
    input  logic [AW-1:0]   rd_pt,
    output logic [2*M-1:0]  piv_val,
    output logic [2*M-1:0]  rest_val
);

    localparam int PDEPTH = 2*NLEV;
    localparam int RDEPTH = (NLEV+1)*NPT;

    // Pivot RAM: the two candidate points of each level, used as discrepancies.
    logic [2*M-1:0] piv_mem  [PDEPTH];
    // Remaining-point RAM: every other point, one slot set per level.
    logic [2*M-1:0] rest_mem [RDEPTH];

    logic to_piv;
    int   wpi, wri, rpi, rri;

    always_comb begin
        to_piv = (int'(wr_pt) < NPT-1) && ((int'(wr_pt) / 2) == int'(wr_lvl));
        wpi    = int'(wr_lvl)*2 + int'(wr_pt[0]);
        wri    = int'(wr_lvl)*NPT + int'(wr_pt);
        rpi    = int'(rd_lvl)*2 + int'(rd_sel);
        rri    = int'(rd_lvl)*NPT + int'(rd_pt);
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (to_piv && wpi < PDEPTH)
                piv_mem[wpi] <= wr_v;
            else if (!to_piv && wri < RDEPTH)
                rest_mem[wri] <= wr_v;
        end
    end

    assign piv_val  = (rpi < PDEPTH) ? piv_mem[rpi]  : '0;
    assign rest_val = (rri < RDEPTH) ? rest_mem[rri] : '0;

endmodule

// File: rtl/tvt_eval_tree.sv
module tvt_eval_tree
    import tvt_pkg::*;
#(
    parameter int ETA       = 4,
    parameter int M         = 8,
    parameter logic [M:0] POLY = 9'h11D,
    parameter int INIT_DEG1 = 1,
    parameter int NPT       = 2*ETA+1,
    parameter int AW        = $clog2(NPT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [AW-1:0]   ld_pt,
    input  logic [M-1:0]    ld_x,
    input  logic [M-1:0]    ld_v0,
    input  logic [M-1:0]    ld_v1,
    input  logic            start,
    output logic            busy,
    output logic            done,
    output logic [1:0]      found_cnt,
    output logic [ETA-1:0]  first_vec,
    output logic [ETA-1:0]  second_vec,
    output logic            fail
);

    localparam int LW = $clog2(ETA+1);
    localparam int DW = $clog2(ETA+INIT_DEG1+2);
    localparam logic [AW-1:0] TEST_PT = AW'(NPT-1);

    tvt_state_e     state;
    logic [LW-1:0]  lvl;
    logic [AW-1:0]  pt;
    logic [ETA-1:0] path;

    logic [M-1:0]   x_mem  [NPT];
    logic [DW-1:0]  g0_mem [ETA+1];
    logic [DW-1:0]  g1_mem [ETA+1];

    logic           sel;
    logic [2*M-1:0] piv_val, rest_val;
    logic [M-1:0]   n0, n1;
    logic [DW-1:0]  g0, g1, g0n, g1n;
    pivot_e         piv;
    logic           wr_en;
    logic [LW-1:0]  wr_lvl;
    logic [AW-1:0]  wr_pt;
    logic [2*M-1:0] wr_v;
    logic           hit;
    logic [1:0]     found_nx;
    logic [ETA-1:0] path_nx;
    int             back_lvl;

    // Choice bit of the current level and backtrack target.
    always_comb begin
        int bi;
        int hb;
        logic [ETA-1:0] diff;
        bi  = ETA-1-int'(lvl);
        sel = (bi >= 0) ? path[bi] : 1'b0;
        path_nx = path + 1'b1;
        diff = path ^ path_nx;
        hb = 0;
        for (int i = 0; i < ETA; i++)
            if (diff[i]) hb = i;
        back_lvl = ETA-1-hb;
    end

    assign g0  = g0_mem[lvl];
    assign g1  = g1_mem[lvl];
    assign piv = pick_pivot(piv_val[M-1:0] != '0, piv_val[2*M-1:M] != '0, g0 <= g1);

    always_comb begin
        g0n = g0;
        g1n = g1;
        if (piv == PV_Q0) g0n = g0 + 1'b1;
        if (piv == PV_Q1) g1n = g1 + 1'b1;
    end

    tvt_point_update #(.M(M), .POLY(POLY)) u_upd (
        .piv (piv),
        .d0  (piv_val[M-1:0]),
        .d1  (piv_val[2*M-1:M]),
        .xp  (x_mem[2*int'(lvl)]),
        .xj  (x_mem[pt]),
        .v0  (rest_val[M-1:0]),
        .v1  (rest_val[2*M-1:M]),
        .n0  (n0),
        .n1  (n1)
    );

    assign wr_en  = (state == ST_EDGE) || (state == ST_IDLE && ld_en);
    assign wr_lvl = (state == ST_EDGE) ? LW'(int'(lvl)+1) : '0;
    assign wr_pt  = (state == ST_EDGE) ? pt : ld_pt;
    assign wr_v   = (state == ST_EDGE) ? {n1, n0} : {ld_v1, ld_v0};

    tvt_level_store #(.M(M), .NLEV(ETA), .NPT(NPT), .AW(AW), .LW(LW)) u_store (
        .clk      (clk),
        .wr_en    (wr_en),
        .wr_lvl   (wr_lvl),
        .wr_pt    (wr_pt),
        .wr_v     (wr_v),
        .rd_lvl   (lvl),
        .rd_sel   (sel),
        .rd_pt    (pt),
        .piv_val  (piv_val),
        .rest_val (rest_val)
    );

    // Leaf test: lower-degree polynomial at the test point, Q0 on tie.
    assign hit      = (g1 < g0) ? (rest_val[2*M-1:M] == '0) : (rest_val[M-1:0] == '0);
    assign found_nx = found_cnt + {1'b0, hit};

    always_ff @(posedge clk) begin
        if (state == ST_IDLE && ld_en && int'(ld_pt) < NPT)
            x_mem[ld_pt] <= ld_x;
        if (state == ST_IDLE && start) begin
            g0_mem[0] <= '0;
            g1_mem[0] <= DW'(INIT_DEG1);
        end else if (state == ST_EDGE && pt == TEST_PT) begin
            g0_mem[int'(lvl)+1] <= g0n;
            g1_mem[int'(lvl)+1] <= g1n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            lvl        <= '0;
            pt         <= '0;
            path       <= '0;
            found_cnt  <= '0;
            first_vec  <= '0;
            second_vec <= '0;
            fail       <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    path       <= '0;
                    lvl        <= '0;
                    pt         <= AW'(2);
                    found_cnt  <= '0;
                    first_vec  <= '0;
                    second_vec <= '0;
                    fail       <= 1'b0;
                    state      <= ST_EDGE;
                end
                ST_EDGE: begin
                    if (pt == TEST_PT) begin
                        lvl <= LW'(int'(lvl)+1);
                        if (int'(lvl)+1 == ETA)
                            state <= ST_TEST;
                        else
                            pt <= AW'(2*int'(lvl)+4);
                    end else begin
                        pt <= pt + 1'b1;
                    end
                end
                ST_TEST: begin
                    found_cnt <= found_nx;
                    if (hit) begin
                        if (found_cnt == 2'd0) first_vec  <= path;
                        else                   second_vec <= path;
                    end
                    if ((hit && found_cnt == 2'd1) || (&path)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                        fail  <= (found_nx < 2'd2);
                    end else begin
                        path  <= path_nx;
                        lvl   <= LW'(back_lvl);
                        pt    <= AW'(2*back_lvl+2);
                        state <= ST_EDGE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_walk_ends_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));
    assert_found_step_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> (found_cnt == $past(found_cnt) || found_cnt == $past(found_cnt) + 2'd1));
    assert_vec_order_R2: assert property (@(posedge clk) disable iff (rst)
        (done && found_cnt == 2'd2) |-> (first_vec < second_vec));
    assert_fail_consistent_R6: assert property (@(posedge clk) disable iff (rst)
        (done && fail) |-> (found_cnt < 2'd2));
    assert_edge_point_range_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EDGE) |-> (int'(pt) >= 2*int'(lvl)+2 && int'(pt) <= NPT-1));

endmodule

// File: tb/tvt_eval_tree_tb.sv
module tvt_eval_tree_tb;

    localparam int ETA = 4;
    localparam int M   = 4;
    localparam logic [M:0] POLY = 5'h13;
    localparam int NPT = 2*ETA+1;
    localparam int AW  = $clog2(NPT);
    localparam int NV  = 1 << ETA;
    localparam int NSEED = 8;
    localparam logic [15:0] SEEDS [NSEED] = '{16'hACE1, 16'h1234, 16'hBEEF, 16'h0F0F,
                                              16'h5A5A, 16'h7777, 16'hC0DE, 16'h3C21};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ld_en = 1'b0;
    logic [AW-1:0] ld_pt = '0;
    logic [M-1:0] ld_x = '0, ld_v0 = '0, ld_v1 = '0;
    logic start = 1'b0;
    logic busy, done, fail;
    logic [1:0] found_cnt;
    logic [ETA-1:0] first_vec, second_vec;

    always #4 clk = ~clk;

    tvt_eval_tree #(.ETA(ETA), .M(M), .POLY(POLY), .INIT_DEG1(1)) u_dut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_pt(ld_pt), .ld_x(ld_x),
        .ld_v0(ld_v0), .ld_v1(ld_v1), .start(start), .busy(busy), .done(done),
        .found_cnt(found_cnt), .first_vec(first_vec), .second_vec(second_vec), .fail(fail)
    );

    int total = 0;
    int bad = 0;
    int last_cycles = 0;
    logic [M-1:0] rx [NPT];
    logic [M-1:0] r0 [NPT];
    logic [M-1:0] r1 [NPT];

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [M-1:0] gm(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] r = '0;
        logic [M-1:0] t = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) r ^= t;
            t = t[M-1] ? ({t[M-2:0], 1'b0} ^ POLY[M-1:0]) : {t[M-2:0], 1'b0};
        end
        return r;
    endfunction

    // Reference: evaluate one leaf straight from the root values (R3, R4).
    function automatic logic leaf_hits(input int v);
        logic [M-1:0] a0 [NPT];
        logic [M-1:0] a1 [NPT];
        logic [M-1:0] d0, d1, t0, t1, dx;
        int g0, g1, p, pv;
        for (int j = 0; j < NPT; j++) begin a0[j] = r0[j]; a1[j] = r1[j]; end
        g0 = 0; g1 = 1;
        for (int k = 0; k < ETA; k++) begin
            p  = 2*k + ((v >> (ETA-1-k)) & 1);
            d0 = a0[p]; d1 = a1[p];
            if (d0 != 0 && (d1 == 0 || g0 <= g1)) pv = 1;
            else if (d1 != 0) pv = 2;
            else pv = 0;
            for (int j = 2*k+2; j < NPT; j++) begin
                t0 = a0[j]; t1 = a1[j]; dx = rx[j] ^ rx[p];
                if (pv == 1) begin a0[j] = gm(t0, dx); a1[j] = gm(d0, t1) ^ gm(d1, t0); end
                if (pv == 2) begin a1[j] = gm(t1, dx); a0[j] = gm(d1, t0) ^ gm(d0, t1); end
            end
            if (pv == 1) g0++;
            if (pv == 2) g1++;
        end
        return (g1 < g0) ? (a1[NPT-1] == 0) : (a0[NPT-1] == 0);
    endfunction

    task automatic set_x();
        for (int k = 0; k < ETA; k++) begin rx[2*k] = M'(k+2); rx[2*k+1] = M'(k+2); end
        rx[NPT-1] = M'(1);
    endtask

    task automatic load_all();
        for (int i = 0; i < NPT; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_pt = AW'(i); ld_x = rx[i]; ld_v0 = r0[i]; ld_v1 = r1[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Load, walk, compare all outputs against the reference model.
    task automatic run_case(input string tag, input bit disturb);
        int ef, e1, e2, cyc, extra;
        bit got;
        ef = 0; e1 = 0; e2 = 0;
        for (int v = 0; v < NV; v++)
            if (leaf_hits(v) && ef < 2) begin
                if (ef == 0) e1 = v; else e2 = v;
                ef++;
            end
        load_all();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 1; got = 1'b0;
        while (!got && cyc < 4000) begin
            if (disturb && cyc == 6) begin
                start = 1'b1; ld_en = 1'b1; ld_pt = AW'(NPT-1); ld_v0 = 4'h9; ld_v1 = 4'h9; ld_x = 4'h7;
            end
            if (disturb && cyc == 7) begin start = 1'b0; ld_en = 1'b0; end
            if (done) got = 1'b1;
            else begin @(negedge clk); cyc++; end
        end
        last_cycles = cyc;
        chk({tag, " R8 done seen"}, int'(got), 1);
        chk({tag, " R2 found_cnt"}, int'(found_cnt), ef);
        chk({tag, " R6 fail"}, int'(fail), int'(ef < 2));
        if (ef >= 1) chk({tag, " R2 R3 R4 first_vec"}, int'(first_vec), e1);
        if (ef == 2) chk({tag, " R2 R3 R4 second_vec"}, int'(second_vec), e2);
        extra = 0;
        for (int i = 0; i < 12; i++) begin @(negedge clk); if (done) extra++; end
        if (disturb) begin
            chk({tag, " R8 single done pulse"}, extra, 0);
            chk({tag, " R8 result held found"}, int'(found_cnt), ef);
            if (ef >= 1) chk({tag, " R8 result held first"}, int'(first_vec), e1);
        end
    endtask

    initial begin
        #(8 * 190000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int c_zero, c_none;
        set_x();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 found_cnt", int'(found_cnt), 0);

        // Table walk: pseudo-random root values per seed.
        for (int s = 0; s < NSEED; s++) begin
            logic [15:0] st = SEEDS[s];
            for (int j = 0; j < NPT; j++) begin
                st = {st[14:0], st[15] ^ st[13] ^ st[12] ^ st[10]}; r0[j] = st[3:0];
                st = {st[14:0], st[15] ^ st[13] ^ st[12] ^ st[10]}; r1[j] = st[3:0];
            end
            run_case($sformatf("seed%0d", s), s == 2);
        end

        // R5: test point all zero.
        for (int j = 0; j < NPT; j++) begin r0[j] = M'(j+1); r1[j] = M'(j+3); end
        r0[NPT-1] = '0; r1[NPT-1] = '0;
        run_case("R5 zero test point", 1'b0);
        chk("R5 first_vec", int'(first_vec), 0);
        chk("R5 second_vec", int'(second_vec), 1);
        c_zero = last_cycles;

        // R6: no discrepancies anywhere, Q0 lower and nonzero -> no vector qualifies.
        for (int j = 0; j < NPT; j++) begin r0[j] = '0; r1[j] = '0; end
        r0[NPT-1] = 4'h5; r1[NPT-1] = 4'h3;
        run_case("R6 none", 1'b0);
        chk("R6 fail set", int'(fail), 1);
        c_none = last_cycles;
        chk("R7 early stop shorter", int'(c_zero * 2 < c_none), 1);

        // R4: degree tie after a Q0 pivot at level 0 must test Q0.
        for (int j = 0; j < NPT; j++) begin r0[j] = '0; r1[j] = '0; end
        r0[0] = 4'h1; r0[1] = 4'h1;
        r0[NPT-1] = '0; r1[NPT-1] = 4'h5;
        run_case("R4 tie", 1'b0);
        chk("R4 tie found", int'(found_cnt), 2);

        // R3: Q1 pivot when its discrepancy alone is nonzero.
        for (int j = 0; j < NPT; j++) begin r0[j] = M'(j); r1[j] = M'(j ^ 5); end
        r0[0] = '0; r0[1] = '0; r1[NPT-1] = '0;
        run_case("R3 q1 pivot", 1'b0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule